// File: doc/BRIEF.md
# Greedy Garbage Collection Engine

This block reclaims space in a page-organised store whose pages pass through the states free, written and invalid. The write path holds `no_free_i` high when it cannot find a free page. The engine then takes control of the store. It picks the block holding the most invalid pages and reads every page of that block once. Pages that still hold live data are parked in a small auxiliary buffer, together with their logical page address and write-count state. The engine then erases the whole block and writes the parked pages back into the same block, starting at page 0. For each page written back it issues a table update that carries the page's state and logical address.

The write path reports each page it invalidates on `inv_inc_i`/`inv_blk_i`, and the engine keeps one invalid-page counter per block. Collection never starts ahead of need. No pages are moved for wear balancing, so the only extra physical writes are the write-backs, and the engine counts these on `copyback_cnt_o`. If the best candidate block has no invalid page at all, the engine raises `full_err_o` and leaves the store untouched.

Page state codes are 0 for a free page, 1 to `WRITES` for a written page (the number of times it has been written), and `WRITES+1` for an invalid page. The acceptance edge is the clock edge at which the engine is idle and samples `no_free_i` high.

Top module: `gc_engine`

## Requirements
- R1: The engine leaves idle only at an edge where `no_free_i` is sampled high. `busy_o` is high from the cycle after the acceptance edge up to and including the cycle with `done_o` or `full_err_o`. While `no_free_i` stays low, no erase or write is issued.
- R2: Each `inv_inc_i` pulse adds one to the invalid counter of block `inv_blk_i`. The victim is the block with the largest counter, and among equal counters the lowest block index wins.
- R3: The engine reads every page of the victim once, in ascending order. It keeps only pages whose state code is 1 to `WRITES`; pages with code 0 (free) or `WRITES+1` (invalid) are dropped.
- R4: `erase_o` is a single-cycle pulse with `erase_blk_o` equal to the victim. It is high in the cycle that begins NUM_BLK+PAGES+1 edges after the acceptance edge. The victim's invalid counter reads as zero afterwards.
- R5: The kept pages are written back with `fl_wr_o`, one per cycle, starting in the cycle right after the erase. They go into the victim block at pages 0, 1, 2, … in their original page order and carry their original data.
- R6: Each write-back cycle also raises `upd_o` at the same block and page, carrying the page's original state code and logical address.
- R7: `done_o` is a single-cycle pulse in the cycle after the last write-back, or in the cycle after the erase when nothing was kept. That cycle begins NUM_BLK+PAGES+n+2 edges after the acceptance edge, where n is the number of pages kept.
- R8: If the victim's counter is zero, `full_err_o` is high for the one cycle that begins NUM_BLK edges after the acceptance edge. No erase or write follows, and the engine returns to idle.
- R9: `copyback_cnt_o` is zero after reset. It rises by exactly one for every write-back cycle and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| no_free_i | input | 1 | Write path found no free page; request collection |
| inv_inc_i | input | 1 | One page was invalidated |
| inv_blk_i | input | BW | Block of the invalidated page |
| busy_o | output | 1 | Collection in progress |
| rd_blk_o | output | BW | Read address, block |
| rd_pg_o | output | PW | Read address, page |
| pg_state_i | input | SW | State code of the addressed page |
| pg_data_i | input | DATA_W | Data of the addressed page |
| pg_lpa_i | input | LPA_W | Logical address mapped to the addressed page |
| erase_o | output | 1 | Erase strobe |
| erase_blk_o | output | BW | Block to erase |
| fl_wr_o | output | 1 | Page write strobe (write-back) |
| wr_blk_o | output | BW | Write and table-update address, block |
| wr_pg_o | output | PW | Write and table-update address, page |
| wr_data_o | output | DATA_W | Write-back data |
| upd_o | output | 1 | Table update strobe |
| upd_state_o | output | SW | State code to store for the page |
| upd_lpa_o | output | LPA_W | Logical address to map to the page |
| done_o | output | 1 | Collection finished |
| full_err_o | output | 1 | No invalid page anywhere; nothing reclaimed |
| copyback_cnt_o | output | CB_W | Running count of write-back writes |

## Verification
A wrong invalid counter or a wrong scan comparison shows up as the wrong `erase_blk_o` as soon as the erase pulse appears, and cycles later as write-backs to an unexpected block. A buffer slot that is corrupt or skipped shows up on the first wrong write-back beat as a mismatch in data, state or logical address. A miscount of kept pages moves `done_o` off the predicted cycle by the size of the error. A victim counter that is not cleared is revealed at the next collection, which then picks the same block again.

// File: rtl/gc_pkg.sv
package gc_pkg;
   typedef enum logic [2:0] {
      GC_IDLE,
      GC_SCAN,
      GC_CHECK,
      GC_COPY,
      GC_ERASE,
      GC_WBACK,
      GC_DONE
   } gc_phase_e;
endpackage

// File: rtl/gc_inv_counters.sv
module gc_inv_counters #(
   parameter int NUM_BLK = 8,
   parameter int PAGES   = 8,
   parameter int BW      = 3,
   parameter int CW      = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc_i,
   input  logic [BW-1:0] inc_blk_i,
   input  logic          clr_i,
   input  logic [BW-1:0] clr_blk_i,
   input  logic [BW-1:0] rd_blk_i,
   output logic [CW-1:0] rd_cnt_o
);
   logic [NUM_BLK*CW-1:0] flat;

   for (genvar b = 0; b < NUM_BLK; b++) begin : g_cnt
      logic [CW-1:0] c_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            c_q <= '0;
         end else if (clr_i && clr_blk_i == BW'(b)) begin
            c_q <= '0;
         end else if (inc_i && inc_blk_i == BW'(b) && c_q != CW'(PAGES)) begin
            c_q <= c_q + 1'b1;
         end
      end
      assign flat[b*CW +: CW] = c_q;
   end

   assign rd_cnt_o = flat[rd_blk_i*CW +: CW];
endmodule

// File: rtl/gc_victim_scan.sv
module gc_victim_scan #(
   parameter int NUM_BLK = 8,
   parameter int BW      = 3,
   parameter int CW      = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scan_i,
   input  logic [CW-1:0] cnt_i,
   output logic [BW-1:0] idx_o,
   output logic [BW-1:0] best_blk_o,
   output logic [CW-1:0] best_cnt_o,
   output logic          last_o
);
   logic [BW-1:0] idx_q, best_q;
   logic [CW-1:0] bcnt_q;

   assign last_o     = scan_i && (idx_q == BW'(NUM_BLK - 1));
   assign idx_o      = idx_q;
   assign best_blk_o = best_q;
   assign best_cnt_o = bcnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q  <= '0;
         best_q <= '0;
         bcnt_q <= '0;
      end else if (scan_i) begin
         // strict compare keeps the earlier (lower) index on a tie
         if (idx_q == '0 || cnt_i > bcnt_q) begin
            best_q <= idx_q;
            bcnt_q <= cnt_i;
         end
         idx_q <= last_o ? '0 : idx_q + 1'b1;
      end
   end
endmodule

// File: rtl/gc_aux_buf.sv
module gc_aux_buf #(
   parameter int DEPTH  = 8,
   parameter int IW     = 3,
   parameter int CW     = 4,
   parameter int SW     = 2,
   parameter int DATA_W = 16,
   parameter int LPA_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              wr_i,
   input  logic [SW-1:0]     w_state_i,
   input  logic [DATA_W-1:0] w_data_i,
   input  logic [LPA_W-1:0]  w_lpa_i,
   input  logic [IW-1:0]     rd_idx_i,
   output logic [SW-1:0]     r_state_o,
   output logic [DATA_W-1:0] r_data_o,
   output logic [LPA_W-1:0]  r_lpa_o,
   output logic [CW-1:0]     count_o
);
   localparam int EW = SW + DATA_W + LPA_W;

   logic [EW-1:0] mem [DEPTH];
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (wr_i && cnt_q != CW'(DEPTH)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!clr_i && wr_i && cnt_q != CW'(DEPTH)) begin
         mem[cnt_q[IW-1:0]] <= {w_state_i, w_data_i, w_lpa_i};
      end
   end

   assign {r_state_o, r_data_o, r_lpa_o} = mem[rd_idx_i];
   assign count_o = cnt_q;
endmodule

// File: rtl/gc_engine.sv
module gc_engine #(
   parameter int NUM_BLK = 8,
   parameter int PAGES   = 8,
   parameter int WRITES  = 2,
   parameter int DATA_W  = 16,
   parameter int LPA_W   = 8,
   parameter int CB_W    = 16,
   localparam int BW = $clog2(NUM_BLK),
   localparam int PW = $clog2(PAGES),
   localparam int SW = $clog2(WRITES + 2),
   localparam int CW = $clog2(PAGES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              no_free_i,
   input  logic              inv_inc_i,
   input  logic [BW-1:0]     inv_blk_i,
   output logic              busy_o,
   output logic [BW-1:0]     rd_blk_o,
   output logic [PW-1:0]     rd_pg_o,
   input  logic [SW-1:0]     pg_state_i,
   input  logic [DATA_W-1:0] pg_data_i,
   input  logic [LPA_W-1:0]  pg_lpa_i,
   output logic              erase_o,
   output logic [BW-1:0]     erase_blk_o,
   output logic              fl_wr_o,
   output logic [BW-1:0]     wr_blk_o,
   output logic [PW-1:0]     wr_pg_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic              upd_o,
   output logic [SW-1:0]     upd_state_o,
   output logic [LPA_W-1:0]  upd_lpa_o,
   output logic              done_o,
   output logic              full_err_o,
   output logic [CB_W-1:0]   copyback_cnt_o
);
   import gc_pkg::*;

   if (NUM_BLK < 2) begin : g_bad_blk
      $error("gc_engine: NUM_BLK must be at least 2");
   end
   if (PAGES < 2) begin : g_bad_pages
      $error("gc_engine: PAGES must be at least 2");
   end
   if (WRITES < 1) begin : g_bad_writes
      $error("gc_engine: WRITES must be at least 1");
   end
   if (CB_W < 1) begin : g_bad_cbw
      $error("gc_engine: CB_W must be positive");
   end

   gc_phase_e     phase_q;
   logic [BW-1:0] scan_idx, victim;
   logic [CW-1:0] scan_cnt, best_cnt, kept;
   logic          scan_last;
   logic [PW-1:0] pg_q;
   logic [CW-1:0] wb_q;
   logic [CB_W-1:0] cb_q;
   logic          keep_pg;

   assign keep_pg = (phase_q == GC_COPY) && (pg_state_i != '0) &&
                    (pg_state_i <= SW'(WRITES));

   gc_inv_counters #(.NUM_BLK(NUM_BLK), .PAGES(PAGES), .BW(BW), .CW(CW)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .inc_i     (inv_inc_i),
      .inc_blk_i (inv_blk_i),
      .clr_i     (phase_q == GC_ERASE),
      .clr_blk_i (victim),
      .rd_blk_i  (scan_idx),
      .rd_cnt_o  (scan_cnt)
   );

   gc_victim_scan #(.NUM_BLK(NUM_BLK), .BW(BW), .CW(CW)) u_scan (
      .clk        (clk),
      .rst_n      (rst_n),
      .scan_i     (phase_q == GC_SCAN),
      .cnt_i      (scan_cnt),
      .idx_o      (scan_idx),
      .best_blk_o (victim),
      .best_cnt_o (best_cnt),
      .last_o     (scan_last)
   );

   gc_aux_buf #(.DEPTH(PAGES), .IW(PW), .CW(CW), .SW(SW),
                .DATA_W(DATA_W), .LPA_W(LPA_W)) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (phase_q == GC_CHECK),
      .wr_i      (keep_pg),
      .w_state_i (pg_state_i),
      .w_data_i  (pg_data_i),
      .w_lpa_i   (pg_lpa_i),
      .rd_idx_i  (wb_q[PW-1:0]),
      .r_state_o (upd_state_o),
      .r_data_o  (wr_data_o),
      .r_lpa_o   (upd_lpa_o),
      .count_o   (kept)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= GC_IDLE;
         pg_q    <= '0;
         wb_q    <= '0;
         cb_q    <= '0;
      end else begin
         unique case (phase_q)
            GC_IDLE:  if (no_free_i) phase_q <= GC_SCAN;
            GC_SCAN:  if (scan_last) phase_q <= GC_CHECK;
            GC_CHECK: begin
               pg_q    <= '0;
               phase_q <= (best_cnt == '0) ? GC_IDLE : GC_COPY;
            end
            GC_COPY: begin
               pg_q <= pg_q + 1'b1;
               if (pg_q == PW'(PAGES - 1)) phase_q <= GC_ERASE;
            end
            GC_ERASE: begin
               wb_q    <= '0;
               phase_q <= (kept == '0) ? GC_DONE : GC_WBACK;
            end
            GC_WBACK: begin
               wb_q <= wb_q + 1'b1;
               cb_q <= cb_q + 1'b1;
               if (wb_q == kept - 1'b1) phase_q <= GC_DONE;
            end
            GC_DONE:  phase_q <= GC_IDLE;
            default:  phase_q <= GC_IDLE;
         endcase
      end
   end

   assign busy_o         = (phase_q != GC_IDLE);
   assign rd_blk_o       = victim;
   assign rd_pg_o        = pg_q;
   assign erase_o        = (phase_q == GC_ERASE);
   assign erase_blk_o    = victim;
   assign fl_wr_o        = (phase_q == GC_WBACK);
   assign upd_o          = (phase_q == GC_WBACK);
   assign wr_blk_o       = victim;
   assign wr_pg_o        = wb_q[PW-1:0];
   assign done_o         = (phase_q == GC_DONE);
   assign full_err_o     = (phase_q == GC_CHECK) && (best_cnt == '0);
   assign copyback_cnt_o = cb_q;
endmodule

// File: rtl/gc_engine_chk.sv
module gc_engine_chk #(
   parameter int BW   = 3,
   parameter int CB_W = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            no_free_i,
   input logic            busy_o,
   input logic            erase_o,
   input logic [BW-1:0]   erase_blk_o,
   input logic            fl_wr_o,
   input logic [BW-1:0]   wr_blk_o,
   input logic            done_o,
   input logic            full_err_o,
   input logic [CB_W-1:0] copyback_cnt_o
);
   logic [BW-1:0] erased_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) erased_q <= '0;
      else if (erase_o) erased_q <= erase_blk_o;
   end

   assert_start_on_demand_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(no_free_i));

   assert_erase_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      erase_o |=> !erase_o);

   assert_wb_same_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fl_wr_o |-> (wr_blk_o == erased_q));

   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_err_to_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      full_err_o |=> !busy_o);

   assert_cb_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fl_wr_o |=> (copyback_cnt_o == $past(copyback_cnt_o) + 1'b1));

   assert_cb_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !fl_wr_o |=> $stable(copyback_cnt_o));
endmodule

bind gc_engine gc_engine_chk #(.BW(BW), .CB_W(CB_W)) u_gc_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .no_free_i      (no_free_i),
   .busy_o         (busy_o),
   .erase_o        (erase_o),
   .erase_blk_o    (erase_blk_o),
   .fl_wr_o        (fl_wr_o),
   .wr_blk_o       (wr_blk_o),
   .done_o         (done_o),
   .full_err_o     (full_err_o),
   .copyback_cnt_o (copyback_cnt_o)
);

// File: tb/test_gc_engine.sv
`timescale 1ns/1ps
module test_gc_engine;
   localparam int NB = 8;
   localparam int PG = 8;
   localparam int WR = 2;
   localparam int DW = 16;
   localparam int LW = 8;
   localparam int BW = 3;
   localparam int PW = 3;
   localparam int SW = 2;
   localparam logic [SW-1:0] INV = 2'd3;

   logic clk = 0, rst_n = 0;
   logic no_free = 0, inv_inc = 0;
   logic [BW-1:0] inv_blk = '0;
   logic busy, erase, fl_wr, upd, done, full_err;
   logic [BW-1:0] rd_blk, erase_blk, wr_blk;
   logic [PW-1:0] rd_pg, wr_pg;
   logic [SW-1:0] pg_state, upd_state;
   logic [DW-1:0] pg_data, wr_data;
   logic [LW-1:0] pg_lpa, upd_lpa;
   logic [15:0]   cb_cnt;

   logic [SW-1:0] ms [NB][PG];
   logic [DW-1:0] md [NB][PG];
   logic [LW-1:0] ml [NB][PG];
   int mcnt [NB];
   int checks = 0, errors = 0, cb_total = 0;

   always #2.5 clk = ~clk;

   assign pg_state = ms[rd_blk][rd_pg];
   assign pg_data  = md[rd_blk][rd_pg];
   assign pg_lpa   = ml[rd_blk][rd_pg];

   gc_engine i_gc_engine (
      .clk(clk), .rst_n(rst_n), .no_free_i(no_free), .inv_inc_i(inv_inc),
      .inv_blk_i(inv_blk), .busy_o(busy), .rd_blk_o(rd_blk), .rd_pg_o(rd_pg),
      .pg_state_i(pg_state), .pg_data_i(pg_data), .pg_lpa_i(pg_lpa),
      .erase_o(erase), .erase_blk_o(erase_blk), .fl_wr_o(fl_wr),
      .wr_blk_o(wr_blk), .wr_pg_o(wr_pg), .wr_data_o(wr_data), .upd_o(upd),
      .upd_state_o(upd_state), .upd_lpa_o(upd_lpa), .done_o(done),
      .full_err_o(full_err), .copyback_cnt_o(cb_cnt)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic set_block(input int b, input logic [SW-1:0] st [PG]);
      for (int p = 0; p < PG; p++) begin
         ms[b][p] = st[p];
         if (st[p] == INV) begin
            @(negedge clk); inv_inc = 1; inv_blk = BW'(b); mcnt[b]++;
            @(negedge clk); inv_inc = 0;
         end
      end
   endtask

   task automatic run_gc();
      int v, n, cyc, k;
      bit fin, saw_er, exp_err;
      logic [SW-1:0] es [PG];
      logic [DW-1:0] ed [PG];
      logic [LW-1:0] el [PG];
      v = 0;
      for (int b = 1; b < NB; b++) if (mcnt[b] > mcnt[v]) v = b;
      exp_err = (mcnt[v] == 0);
      n = 0;
      for (int p = 0; p < PG; p++)
         if (ms[v][p] != 0 && ms[v][p] != INV) begin
            es[n] = ms[v][p]; ed[n] = md[v][p]; el[n] = ml[v][p]; n++;
         end
      @(negedge clk); no_free = 1;
      cyc = 0; k = 0; fin = 0; saw_er = 0;
      while (!fin && cyc < 200) begin
         @(negedge clk); cyc++;
         if (cyc == 1) no_free = 0;
         chk(busy == 1, "R1 busy window", busy, 1);
         if (erase) begin
            saw_er = 1;
            chk(!exp_err && erase_blk == BW'(v), "R2 victim block", erase_blk, v);
            chk(cyc == NB + PG + 2, "R4 erase cycle", cyc, NB + PG + 2);
            for (int p = 0; p < PG; p++) ms[v][p] = '0;
            mcnt[v] = 0;
         end
         if (fl_wr) begin
            chk(upd == 1 && saw_er, "R6 update with write", upd, 1);
            chk(wr_blk == BW'(v) && wr_pg == PW'(k), "R5 write-back address",
                wr_blk * PG + wr_pg, v * PG + k);
            chk(k < n && wr_data == ed[k], "R3/R5 write-back data", wr_data, ed[k]);
            chk(upd_state == es[k] && upd_lpa == el[k], "R6 state/lpa",
                upd_state * 256 + upd_lpa, es[k] * 256 + el[k]);
            md[v][wr_pg] = wr_data; ms[v][wr_pg] = upd_state; ml[v][wr_pg] = upd_lpa;
            k++;
         end
         if (done) begin
            fin = 1;
            chk(!exp_err && cyc == NB + PG + n + 3, "R7 done cycle", cyc, NB + PG + n + 3);
            chk(k == n, "R3 kept page count", k, n);
         end
         if (full_err) begin
            fin = 1;
            chk(exp_err && cyc == NB + 1, "R8 error cycle", cyc, NB + 1);
         end
      end
      chk(fin, "R7 collection completes", fin, 1);
      @(negedge clk);
      chk(busy == 0, "R1 idle after collection", busy, 0);
      if (exp_err) begin
         chk(!saw_er && k == 0, "R8 nothing touched", saw_er + k, 0);
      end else begin
         for (int p = 0; p < PG; p++)
            if (p < n) chk(ms[v][p] == es[p] && md[v][p] == ed[p] && ml[v][p] == el[p],
                           "R5 block content", md[v][p], ed[p]);
            else chk(ms[v][p] == 0, "R4 freed page", ms[v][p], 0);
      end
      cb_total += n;
      chk(cb_cnt == 16'(cb_total), "R9 copy-back count", cb_cnt, cb_total);
   endtask

   initial begin
      logic [SW-1:0] st [PG];
      for (int b = 0; b < NB; b++) begin
         mcnt[b] = 0;
         for (int p = 0; p < PG; p++) begin
            ms[b][p] = 2'd1;
            md[b][p] = DW'(b * 256 + p * 16 + 5);
            ml[b][p] = LW'(b * PG + p);
         end
      end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(busy == 0 && done == 0 && full_err == 0, "R1 reset idle", busy, 0);
      chk(erase == 0 && fl_wr == 0, "R4 reset no erase/write", erase + fl_wr, 0);
      chk(cb_cnt == 0, "R9 reset count", cb_cnt, 0);

      st = '{2'd1, INV, 2'd2, INV, 2'd1, 2'd0, INV, 2'd2};  set_block(3, st);
      st = '{INV, 2'd1, INV, 2'd2, 2'd2, 2'd1, INV, 2'd1}; set_block(5, st);
      st = '{2'd2, INV, 2'd1, 2'd1, INV, 2'd1, 2'd1, 2'd1}; set_block(6, st);

      // R1: no request, no activity
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         chk(busy == 0 && erase == 0 && fl_wr == 0, "R1 no start without request",
             busy + erase + fl_wr, 0);
      end

      run_gc();   // tie 3 vs 5 -> block 3 (R2)
      run_gc();   // block 3 cleared -> block 5 (R4)
      run_gc();   // block 6
      st = '{INV, INV, INV, INV, INV, INV, INV, INV}; set_block(0, st);
      run_gc();   // all invalid, nothing kept (R7)
      run_gc();   // all counters zero -> error (R8)

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule